// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the decode stage of a small hart that has machine, supervisor and user levels. Each cycle it receives one decoded system operation: an environment call, a supervisor return, a wait-for-interrupt, an address-translation fence, an invalidate-ordering fence, or a CSR read or write. It also receives the current privilege level and the status and enable bits that bear on the decision. It reports whether the operation is illegal and whether a trap must be taken, and it gives the cause code for that trap. It also raises side-effect requests for a wait state and for a translation-cache flush. The trap sequencing that follows is done elsewhere.

The decision depends on more than the opcode. It combines the privilege level, the trap-override status bits (return trap, wait trap, translation trap), the access-type and privilege subfields of the CSR address, and a few CSR addresses that need special handling. The hypervisor-style virtual levels are not supported. When the virtual bit is set, or when the reserved level encoding is presented, the block flags the mode as unsupported and rejects the operation.

All outputs are registered. The verdict for the inputs present at one rising edge is visible from that edge until the next one.

Top module: `priv_legal_check`

## Requirements
- R1: Operation code 0 (environment call) is never illegal. It sets trap_o and gives cause 8 at level 00 (user), 9 at level 01 (supervisor) and 11 at level 11 (machine).
- R2: Operation code 1 (supervisor return) is illegal at user level. At supervisor level it is illegal when s_present_i is 0 or tsr_i is 1. At machine level it is illegal when s_present_i is 0.
- R3: Operation code 2 (wait for interrupt) is illegal at user level, and at supervisor level when tw_i is 1. In every other case it is legal and raises wait_o.
- R4: Operation code 3 (translation fence) is legal at machine level, and at supervisor level only when tvm_i is 0. It is illegal at user level. When legal it raises flush_o.
- R5: Operation code 4 (invalidate-ordering fence) is illegal at user level. At supervisor and machine level it is legal and raises no side-effect flag.
- R6: For operation code 6 (CSR write), a CSR address whose bits [11:10] are 11 is read-only, and the write is illegal.
- R7: For operation codes 5 (CSR read) and 6 (CSR write), the access is illegal when the numeric value of the level is below CSR address bits [9:8].
- R8: A CSR access to address 0x180 is illegal at supervisor level while tvm_i is 1.
- R9: A CSR access to 0x14D or 0x15D is always allowed at machine level, is allowed at supervisor level only when tm_en_i and stce_i are both 1, and is never allowed at user level.
- R10: When virt_i is 1, or the level is the reserved code 10, the block raises unsupported_o and illegal_o for every operation code. In that case wait_o and flush_o stay 0.
- R11: An illegal operation sets trap_o with cause 2. A legal operation other than the environment call, including operation code 7 (no system operation), gives trap_o 0 and cause 0.
- R12: Outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge. While rst_n is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_i | input | 2 | Nominal privilege level: 00 user, 01 supervisor, 11 machine, 10 reserved |
| virt_i | input | 1 | Virtual-mode bit |
| op_i | input | 3 | Operation class, codes 0 to 7 as in the requirements |
| csr_addr_i | input | 12 | CSR address for codes 5 and 6 |
| tsr_i | input | 1 | Trap supervisor return |
| tw_i | input | 1 | Trap wait-for-interrupt |
| tvm_i | input | 1 | Trap translation management |
| tm_en_i | input | 1 | Machine counter-enable bit for the timer |
| stce_i | input | 1 | Supervisor timer-compare enable |
| s_present_i | input | 1 | Supervisor level is implemented |
| illegal_o | output | 1 | Operation is illegal |
| trap_o | output | 1 | A trap must be taken |
| cause_o | output | 5 | Trap cause code |
| unsupported_o | output | 1 | Virtual or reserved level presented |
| wait_o | output | 1 | Enter the wait state |
| flush_o | output | 1 | Request a translation-cache flush |

## Verification
The bench sweeps every combination of level, virtual bit, operation code and the six status and enable bits. The CSR operations are run against a set of addresses that includes a read-only user counter, a machine register, a plain supervisor register, the translation register, both timer-compare registers and a neighbour of them. For each combination, the bench works out the verdict from the requirements. This shows apart the following cases:
- a check keyed on the privilege field from a check keyed on the exact address, because 0x14E differs from 0x14D only in the address match;
- the return trap from the wait trap and from the translation trap;
- a legal non-trapping operation from an environment call.

A reset phase with active inputs confirms that reset takes priority over the computed verdict.

// File: rtl/priv_check_pkg.sv
package priv_check_pkg;

    localparam int LVL_W   = 2;
    localparam int OP_W    = 3;
    localparam int CSR_W   = 12;
    localparam int CAUSE_W = 5;

    typedef enum logic [LVL_W-1:0] {
        LVL_USER  = 2'b00,
        LVL_SUPER = 2'b01,
        LVL_RSVD  = 2'b10,
        LVL_MACH  = 2'b11
    } lvl_e;

    typedef enum logic [OP_W-1:0] {
        OP_ECALL   = 3'd0,
        OP_SRET    = 3'd1,
        OP_WFI     = 3'd2,
        OP_TFENCE  = 3'd3,
        OP_IFENCE  = 3'd4,
        OP_CSR_RD  = 3'd5,
        OP_CSR_WR  = 3'd6,
        OP_NONE    = 3'd7
    } op_e;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(2);
    localparam logic [CAUSE_W-1:0] CAUSE_ENV_U   = CAUSE_W'(8);
    localparam logic [CAUSE_W-1:0] CAUSE_ENV_S   = CAUSE_W'(9);
    localparam logic [CAUSE_W-1:0] CAUSE_ENV_M   = CAUSE_W'(11);

    localparam logic [CSR_W-1:0] CSR_XLAT   = 12'h180;
    localparam logic [CSR_W-1:0] CSR_TCMP_A = 12'h14D;
    localparam logic [CSR_W-1:0] CSR_TCMP_B = 12'h15D;

    typedef struct packed {
        logic               illegal;
        logic               trap;
        logic [CAUSE_W-1:0] cause;
        logic               unsupported;
        logic               wait_req;
        logic               flush;
    } verdict_t;

endpackage

// File: rtl/sys_op_rules.sv
module sys_op_rules
    import priv_check_pkg::*;
(
    input  lvl_e               lvl,
    input  op_e                op,
    input  logic               tsr,
    input  logic               tw,
    input  logic               tvm,
    input  logic               s_present,
    output logic               illegal,
    output logic               env_trap,
    output logic [CAUSE_W-1:0] env_cause,
    output logic               wait_req,
    output logic               flush
);

    always_comb begin
        illegal   = 1'b0;
        env_trap  = 1'b0;
        env_cause = '0;
        wait_req  = 1'b0;
        flush     = 1'b0;
        unique case (op)
            OP_ECALL: begin
                env_trap = 1'b1;
                case (lvl)
                    LVL_USER:  env_cause = CAUSE_ENV_U;
                    LVL_SUPER: env_cause = CAUSE_ENV_S;
                    default:   env_cause = CAUSE_ENV_M;
                endcase
            end
            OP_SRET: begin
                case (lvl)
                    LVL_USER:  illegal = 1'b1;
                    LVL_SUPER: illegal = !s_present || tsr;
                    default:   illegal = !s_present;
                endcase
            end
            OP_WFI: begin
                case (lvl)
                    LVL_USER:  illegal = 1'b1;
                    LVL_SUPER: illegal = tw;
                    default:   illegal = 1'b0;
                endcase
                wait_req = !illegal;
            end
            OP_TFENCE: begin
                case (lvl)
                    LVL_USER:  illegal = 1'b1;
                    LVL_SUPER: illegal = tvm;
                    default:   illegal = 1'b0;
                endcase
                flush = !illegal;
            end
            OP_IFENCE: illegal = (lvl == LVL_USER);
            default: ;
        endcase
    end

endmodule

// File: rtl/csr_rules.sv
module csr_rules
    import priv_check_pkg::*;
(
    input  lvl_e             lvl,
    input  logic             access,
    input  logic             is_write,
    input  logic [CSR_W-1:0] addr,
    input  logic             tvm,
    input  logic             tm_en,
    input  logic             stce,
    output logic             illegal
);

    localparam int RO_HI = CSR_W - 1;
    localparam int RO_LO = CSR_W - 2;
    localparam int PV_HI = CSR_W - 3;
    localparam int PV_LO = CSR_W - 4;

    logic ro_fault;
    logic lvl_fault;
    logic xlat_fault;
    logic tcmp_fault;
    logic is_tcmp;

    always_comb begin
        ro_fault   = is_write && (addr[RO_HI:RO_LO] == 2'b11);
        lvl_fault  = (lvl < addr[PV_HI:PV_LO]);
        xlat_fault = (addr == CSR_XLAT) && (lvl == LVL_SUPER) && tvm;
        is_tcmp    = (addr == CSR_TCMP_A) || (addr == CSR_TCMP_B);
        tcmp_fault = 1'b0;
        if (is_tcmp) begin
            case (lvl)
                LVL_MACH:  tcmp_fault = 1'b0;
                LVL_SUPER: tcmp_fault = !(tm_en && stce);
                default:   tcmp_fault = 1'b1;
            endcase
        end
        illegal = access && (ro_fault || lvl_fault || xlat_fault || tcmp_fault);
    end

endmodule

// File: rtl/priv_legal_check.sv
module priv_legal_check
    import priv_check_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   lvl_i,
    input  logic               virt_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [CSR_W-1:0]   csr_addr_i,
    input  logic               tsr_i,
    input  logic               tw_i,
    input  logic               tvm_i,
    input  logic               tm_en_i,
    input  logic               stce_i,
    input  logic               s_present_i,
    output logic               illegal_o,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               unsupported_o,
    output logic               wait_o,
    output logic               flush_o
);

    lvl_e lvl;
    op_e  op;
    assign lvl = lvl_e'(lvl_i);
    assign op  = op_e'(op_i);

    logic               sys_illegal;
    logic               env_trap;
    logic [CAUSE_W-1:0] env_cause;
    logic               sys_wait;
    logic               sys_flush;
    logic               csr_illegal;
    logic               csr_access;

    assign csr_access = (op == OP_CSR_RD) || (op == OP_CSR_WR);

    sys_op_rules u_sys (
        .lvl       (lvl),
        .op        (op),
        .tsr       (tsr_i),
        .tw        (tw_i),
        .tvm       (tvm_i),
        .s_present (s_present_i),
        .illegal   (sys_illegal),
        .env_trap  (env_trap),
        .env_cause (env_cause),
        .wait_req  (sys_wait),
        .flush     (sys_flush)
    );

    csr_rules u_csr (
        .lvl      (lvl),
        .access   (csr_access),
        .is_write (op == OP_CSR_WR),
        .addr     (csr_addr_i),
        .tvm      (tvm_i),
        .tm_en    (tm_en_i),
        .stce     (stce_i),
        .illegal  (csr_illegal)
    );

    verdict_t verdict_d;
    verdict_t verdict_q;

    always_comb begin
        verdict_d = '0;
        if (virt_i || (lvl == LVL_RSVD)) begin
            verdict_d.unsupported = 1'b1;
            verdict_d.illegal     = 1'b1;
        end else begin
            verdict_d.illegal  = sys_illegal || csr_illegal;
            verdict_d.wait_req = sys_wait;
            verdict_d.flush    = sys_flush;
        end
        if (verdict_d.illegal) begin
            verdict_d.trap  = 1'b1;
            verdict_d.cause = CAUSE_ILLEGAL;
        end else if (env_trap) begin
            verdict_d.trap  = 1'b1;
            verdict_d.cause = env_cause;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign illegal_o     = verdict_q.illegal;
    assign trap_o        = verdict_q.trap;
    assign cause_o       = verdict_q.cause;
    assign unsupported_o = verdict_q.unsupported;
    assign wait_o        = verdict_q.wait_req;
    assign flush_o       = verdict_q.flush;

    AST_ECALL_USER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && !virt_i && lvl_i == 2'b00) |=> (trap_o && !illegal_o && cause_o == CAUSE_W'(8))); // R1

    AST_SRET_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && lvl_i == 2'b00) |=> illegal_o); // R2

    AST_RO_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 && csr_addr_i[11:10] == 2'b11) |=> illegal_o); // R6

    AST_VIRT_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        virt_i |=> (unsupported_o && illegal_o && !wait_o && !flush_o)); // R10

    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (trap_o && cause_o == CAUSE_W'(2) && !wait_o && !flush_o)); // R11

    AST_SIDE_EFFECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wait_o, flush_o, trap_o}) <= 1); // R11

    AST_STABLE_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(op_i) && $stable(lvl_i) && $stable(virt_i) && $stable(csr_addr_i)
        && $stable(tsr_i) && $stable(tw_i) && $stable(tvm_i) && $stable(tm_en_i)
        && $stable(stce_i) && $stable(s_present_i) && $past(rst_n)
        |=> $stable(illegal_o) && $stable(cause_o)); // R12

endmodule

// File: tb/tb_priv_legal_check.sv
`timescale 1ns/1ps
module tb_priv_legal_check;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  lvl_i;
    logic        virt_i;
    logic [2:0]  op_i;
    logic [11:0] csr_addr_i;
    logic        tsr_i, tw_i, tvm_i, tm_en_i, stce_i, s_present_i;
    logic        illegal_o, trap_o, unsupported_o, wait_o, flush_o;
    logic [4:0]  cause_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    priv_legal_check dut (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .virt_i(virt_i), .op_i(op_i),
        .csr_addr_i(csr_addr_i), .tsr_i(tsr_i), .tw_i(tw_i), .tvm_i(tvm_i),
        .tm_en_i(tm_en_i), .stce_i(stce_i), .s_present_i(s_present_i),
        .illegal_o(illegal_o), .trap_o(trap_o), .cause_o(cause_o),
        .unsupported_o(unsupported_o), .wait_o(wait_o), .flush_o(flush_o)
    );

    logic [11:0] addrs [8];
    initial begin
        addrs[0] = 12'hC00; addrs[1] = 12'h300; addrs[2] = 12'h100; addrs[3] = 12'h180;
        addrs[4] = 12'h14D; addrs[5] = 12'h15D; addrs[6] = 12'h14E; addrs[7] = 12'h040;
    end

    // expected: {illegal, trap, cause[4:0], unsupported, wait, flush}
    function automatic logic [9:0] model(input logic [1:0] l, input logic v, input logic [2:0] o,
                                         input logic [11:0] a, input logic [5:0] b);
        logic tsr, tw, tvm, tm, st, sp;
        logic bad, unsup, wt, fl, env;
        int   lv, need;
        logic [4:0] c;
        {tsr, tw, tvm, tm, st, sp} = b;
        lv = int'(l);
        unsup = v || (l == 2'b10);
        bad = 0; wt = 0; fl = 0; env = 0; c = 0;
        if (o == 3'd0) begin env = 1; c = (lv == 0) ? 5'd8 : (lv == 1) ? 5'd9 : 5'd11; end
        if (o == 3'd1) bad = (lv == 0) || !sp || (lv == 1 && tsr);            // R2
        if (o == 3'd2) begin bad = (lv == 0) || (lv == 1 && tw); wt = !bad; end // R3
        if (o == 3'd3) begin bad = (lv == 0) || (lv == 1 && tvm); fl = !bad; end // R4
        if (o == 3'd4) bad = (lv == 0);                                       // R5
        if (o == 3'd5 || o == 3'd6) begin
            need = int'(a[9:8]);
            if (o == 3'd6 && a[11:10] == 2'b11) bad = 1;                      // R6
            if (lv < need) bad = 1;                                           // R7
            if (a == 12'h180 && lv == 1 && tvm) bad = 1;                      // R8
            if ((a == 12'h14D || a == 12'h15D) && lv != 3 && !(lv == 1 && tm && st)) bad = 1; // R9
        end
        if (unsup) begin bad = 1; wt = 0; fl = 0; end                         // R10
        if (bad) return {1'b1, 1'b1, 5'd2, unsup, 1'b0, 1'b0};                // R11
        return {1'b0, env, env ? c : 5'd0, 1'b0, wt, fl};
    endfunction

    task automatic check(input logic [9:0] exp, input string tag);
        logic [9:0] act;
        act = {illegal_o, trap_o, cause_o, unsupported_o, wait_o, flush_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lvl=%0d virt=%0d op=%0d addr=%h bits=%b actual=%b expected=%b",
                     tag, lvl_i, virt_i, op_i, csr_addr_i,
                     {tsr_i, tw_i, tvm_i, tm_en_i, stce_i, s_present_i}, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic [11:0] a, input logic v, input logic [1:0] l);
        if (v || l == 2'b10) return "R10";
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd7: return "R11";
            default: begin
                if (a == 12'h180) return "R8";
                if (a == 12'h14D || a == 12'h15D) return "R9";
                if (o == 3'd6 && a[11:10] == 2'b11) return "R6";
                return "R7";
            end
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [9:0] exp_q;
        string      tag_q;
        rst_n = 0; lvl_i = 2'b00; virt_i = 1; op_i = 3'd0; csr_addr_i = 12'h180;
        {tsr_i, tw_i, tvm_i, tm_en_i, stce_i, s_present_i} = 6'b111111;
        repeat (3) @(negedge clk);
        check(10'd0, "R12 reset");
        op_i = 3'd2; lvl_i = 2'b11; virt_i = 0;
        @(negedge clk);
        check(10'd0, "R12 reset");
        rst_n = 1;
        // R12: drive at a falling edge, sample one full cycle later
        exp_q = model(lvl_i, virt_i, op_i, csr_addr_i, 6'b111111);
        tag_q = "R12";
        @(negedge clk);
        check(exp_q, tag_q);
        for (int l = 0; l < 4; l++)
            for (int v = 0; v < 2; v++)
                for (int o = 0; o < 8; o++)
                    for (int b = 0; b < 64; b++)
                        for (int ai = 0; ai < 8; ai++) begin
                            if ((o != 5 && o != 6) && ai != 0) continue;
                            lvl_i = 2'(l); virt_i = 1'(v); op_i = 3'(o); csr_addr_i = addrs[ai];
                            {tsr_i, tw_i, tvm_i, tm_en_i, stce_i, s_present_i} = 6'(b);
                            exp_q = model(2'(l), 1'(v), 3'(o), addrs[ai], 6'(b));
                            tag_q = tag_of(3'(o), addrs[ai], 1'(v), 2'(l));
                            @(negedge clk);
                            check(exp_q, tag_q);
                        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule